// File: doc/BRIEF.md
# Receive-Clock Delay-Line Calibration and Phase Tuner

This block calibrates a tapped delay line on the receive clock and then chooses a sampling phase for it. A single start pulse launches a two-stage search. The first stage sweeps a unit-delay code upward from zero. At each code it reads back the measured line length and keeps the first code whose length fits within the tap range. The second stage steps the tap select through every usable phase. At each phase it asks an external sequencer to run a tuning-pattern check, records the longest unbroken run of passing phases, and finally programs the phase at the centre of that run.

The block drives the delay line through a unit code, a tap select, a delay-enable bit, a sampler-enable bit and a one-cycle configuration-write strobe. The line answers with a length-valid flag and a 12-bit length. The tuning check uses a request/done/pass handshake. When the search ends, a one-cycle `done_o` is raised with a 2-bit error code: 0 for success, 1 when no unit code was accepted, 2 when no phase passed. The chosen unit code and phase are held in output registers until the next start.

The controller has nine named states. IDLE waits for start. CAL_SET writes a unit code with tap select 12. CAL_WAIT waits for the length or a timeout and accepts the code or steps to the next one. PH_SET writes a trial phase. PH_REQ issues the check request. PH_WAIT waits for the check result. PH_NEXT either advances the phase or ends the sweep. FINAL_SET writes the centre phase. FINISH pulses done. The transitions are: IDLE→CAL_SET on start; CAL_SET→CAL_WAIT; CAL_WAIT→PH_SET on accept; CAL_WAIT→CAL_SET on reject or timeout below the last code; CAL_WAIT→FINISH on reject or timeout at the last code; PH_SET→PH_REQ→PH_WAIT; PH_WAIT→PH_NEXT on check done; PH_NEXT→PH_SET when phases remain; PH_NEXT→FINAL_SET when a window exists; PH_NEXT→FINISH when none does; FINAL_SET→FINISH; FINISH→IDLE.

Top module: `dlyt_tuner`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o`, `dl_delay_en_o`, `dl_sampler_en_o`, `chk_req_o` are 0 and `final_unit_o`, `final_phase_o`, `err_code_o` are 0.
- R2: Calibration writes unit codes in increasing order starting at 0. Each write is a `dl_cfg_wr_o` pulse with `dl_sel_o` = 12 and both `dl_sampler_en_o` and `dl_delay_en_o` at 1.
- R3: When `dl_len_valid_i` has not been seen within TIMEOUT_CYC cycles after a unit write, the block moves on to the next unit code.
- R4: A unit code is accepted when its length is nonzero and below 2048. The highest phase tried is then the index of the most significant set bit of that length. A length of 0 or of 2048 and above is rejected.
- R5: When unit code 127 is rejected or times out, the block ends with `done_o`=1, `err_o`=1 and `err_code_o`=1.
- R6: Phases 0 up to the highest phase are each tried once, in order. Each trial writes the phase to `dl_sel_o` with `dl_delay_en_o`=1 and `dl_sampler_en_o`=0, raises `chk_req_o` for one cycle, and waits for `chk_done_i`.
- R7: A failing check resets the current run to 0 and a passing one extends it. The best run is replaced only when the current run is strictly longer, so among equal runs the earliest is kept.
- R8: On success, the final phase equals the last phase of the best run minus half its length, rounded down. It is written to the line with a `dl_cfg_wr_o` pulse and shown on `final_phase_o`, with the accepted code on `final_unit_o`.
- R9: When no phase passes, the block ends with `done_o`=1, `err_o`=1 and `err_code_o`=2.
- R10: `done_o` lasts exactly one cycle and `err_o` is raised only together with it. While idle, the final unit, the final phase and `dl_sel_o` stay unchanged until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch a calibration and tuning run (taken only in IDLE) |
| dl_unit_o | output | 7 | Unit-delay code to the delay line |
| dl_sel_o | output | 4 | Tap select to the delay line |
| dl_delay_en_o | output | 1 | Delay-line enable |
| dl_sampler_en_o | output | 1 | Length-measurement sampler enable |
| dl_cfg_wr_o | output | 1 | One-cycle strobe applying unit/select/enables |
| dl_len_valid_i | input | 1 | Measured length is valid |
| dl_len_i | input | 12 | Measured line length |
| chk_req_o | output | 1 | One-cycle request for a tuning-pattern check |
| chk_done_i | input | 1 | Tuning check finished |
| chk_pass_i | input | 1 | Tuning check result, valid with chk_done_i |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Run ended in error (with done_o) |
| err_code_o | output | 2 | 0 ok, 1 no unit accepted, 2 no passing phase |
| final_unit_o | output | 7 | Accepted unit code |
| final_phase_o | output | 4 | Selected sampling phase |

## Verification
Calibration is driven with line models that reject early codes for an oversized length, time out on early codes, return a zero length, and return exactly 2048. These show the timeout path, both ends of the acceptance bound, and the sweep that runs out at code 127. The phase search is fed pass patterns with two equal windows, a window reaching the last phase, an all-pass sweep and an all-fail sweep. Together they tell apart strict from non-strict best-run replacement, a missed window at sweep end, the rounding of the centre, and the no-window error. A single-phase case with a maximum phase of 0 covers the smallest sweep.

// File: rtl/dlyt_pkg.sv
`timescale 1ns/1ps
package dlyt_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CAL_SET,
        S_CAL_WAIT,
        S_PH_SET,
        S_PH_REQ,
        S_PH_WAIT,
        S_PH_NEXT,
        S_FINAL_SET,
        S_FINISH
    } tuner_state_e;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_CAL   = 2'd1,
        ERR_NOWIN = 2'd2
    } tuner_err_e;

    // Index of the most significant set bit (0 when the value is 0).
    function automatic logic [4:0] top_bit(input logic [15:0] v);
        logic [4:0] idx;
        idx = '0;
        for (int i = 0; i < 16; i++) begin
            if (v[i]) idx = 5'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/dlyt_timeout.sv
`timescale 1ns/1ps
module dlyt_timeout #(
    parameter int TIMEOUT_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (run && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/dlyt_window.sv
`timescale 1ns/1ps
module dlyt_window #(
    parameter int PH_W  = 4,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             upd,
    input  logic             pass,
    input  logic [PH_W-1:0]  phase,
    output logic [CNT_W-1:0] best_len,
    output logic [PH_W-1:0]  centre
);
    logic [CNT_W-1:0] cur_q, best_q;
    logic [PH_W-1:0]  end_q;
    logic [CNT_W-1:0] cur_inc;

    assign cur_inc = cur_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            best_q <= '0;
            end_q  <= '0;
        end else if (clear) begin
            cur_q  <= '0;
            best_q <= '0;
            end_q  <= '0;
        end else if (upd) begin
            if (!pass) begin
                cur_q <= '0;
            end else begin
                cur_q <= cur_inc;
                if (cur_inc > best_q) begin
                    best_q <= cur_inc;
                    end_q  <= phase;
                end
            end
        end
    end

    logic [CNT_W-1:0] half;
    assign half     = best_q >> 1;
    assign best_len = best_q;
    assign centre   = end_q - PH_W'(half);
endmodule

// File: rtl/dlyt_tuner.sv
`timescale 1ns/1ps
module dlyt_tuner #(
    parameter int UNIT_W      = 7,
    parameter int SEL_W       = 4,
    parameter int LEN_W       = 12,
    parameter int NB_DELAY    = 11,
    parameter int TIMEOUT_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic [UNIT_W-1:0] dl_unit_o,
    output logic [SEL_W-1:0]  dl_sel_o,
    output logic              dl_delay_en_o,
    output logic              dl_sampler_en_o,
    output logic              dl_cfg_wr_o,
    input  logic              dl_len_valid_i,
    input  logic [LEN_W-1:0]  dl_len_i,
    output logic              chk_req_o,
    input  logic              chk_done_i,
    input  logic              chk_pass_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [1:0]        err_code_o,
    output logic [UNIT_W-1:0] final_unit_o,
    output logic [SEL_W-1:0]  final_phase_o
);
    import dlyt_pkg::*;

    localparam logic [UNIT_W-1:0] UNIT_LAST = {UNIT_W{1'b1}};
    localparam logic [SEL_W-1:0]  SEL_CAL   = SEL_W'(NB_DELAY + 1);
    localparam logic [LEN_W-1:0]  LEN_LIMIT = LEN_W'(1 << NB_DELAY);
    localparam int                CNT_W     = $clog2(NB_DELAY + 1);

    tuner_state_e state_q, state_d;

    logic [UNIT_W-1:0] unit_q;
    logic [SEL_W-1:0]  phase_q, max_q;
    tuner_err_e        err_q;
    logic [UNIT_W-1:0] fin_unit_q;
    logic [SEL_W-1:0]  fin_phase_q;
    logic              locked_q;

    logic              tmo_expired;
    logic [CNT_W-1:0]  win_best;
    logic [SEL_W-1:0]  win_centre;
    logic              len_ok;
    logic              win_clear, win_upd;

    assign len_ok    = (dl_len_i != '0) && (dl_len_i < LEN_LIMIT);
    assign win_clear = (state_q == S_IDLE) && start_i;
    assign win_upd   = (state_q == S_PH_WAIT) && chk_done_i;

    dlyt_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_q == S_CAL_SET),
        .run     (state_q == S_CAL_WAIT),
        .expired (tmo_expired)
    );

    dlyt_window #(.PH_W(SEL_W), .CNT_W(CNT_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (win_clear),
        .upd      (win_upd),
        .pass     (chk_pass_i),
        .phase    (phase_q),
        .best_len (win_best),
        .centre   (win_centre)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (start_i) state_d = S_CAL_SET;
            S_CAL_SET:   state_d = S_CAL_WAIT;
            S_CAL_WAIT: begin
                if (dl_len_valid_i && len_ok) begin
                    state_d = S_PH_SET;
                end else if (dl_len_valid_i || tmo_expired) begin
                    state_d = (unit_q == UNIT_LAST) ? S_FINISH : S_CAL_SET;
                end
            end
            S_PH_SET:    state_d = S_PH_REQ;
            S_PH_REQ:    state_d = S_PH_WAIT;
            S_PH_WAIT:   if (chk_done_i) state_d = S_PH_NEXT;
            S_PH_NEXT: begin
                if (phase_q != max_q)   state_d = S_PH_SET;
                else if (win_best == '0) state_d = S_FINISH;
                else                     state_d = S_FINAL_SET;
            end
            S_FINAL_SET: state_d = S_FINISH;
            S_FINISH:    state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // State and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            unit_q      <= '0;
            phase_q     <= '0;
            max_q       <= '0;
            err_q       <= ERR_NONE;
            fin_unit_q  <= '0;
            fin_phase_q <= '0;
            locked_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        unit_q      <= '0;
                        phase_q     <= '0;
                        err_q       <= ERR_NONE;
                        fin_unit_q  <= '0;
                        fin_phase_q <= '0;
                        locked_q    <= 1'b0;
                    end
                end
                S_CAL_WAIT: begin
                    if (dl_len_valid_i && len_ok) begin
                        max_q   <= SEL_W'(top_bit(16'(dl_len_i)));
                        phase_q <= '0;
                    end else if (dl_len_valid_i || tmo_expired) begin
                        if (unit_q == UNIT_LAST) err_q  <= ERR_CAL;
                        else                     unit_q <= unit_q + 1'b1;
                    end
                end
                S_PH_NEXT: begin
                    if (phase_q != max_q)    phase_q <= phase_q + 1'b1;
                    else if (win_best == '0) err_q   <= ERR_NOWIN;
                    else                     phase_q <= win_centre;
                end
                S_FINAL_SET: begin
                    fin_unit_q  <= unit_q;
                    fin_phase_q <= phase_q;
                    locked_q    <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        dl_unit_o       = unit_q;
        dl_sel_o        = phase_q;
        dl_sampler_en_o = 1'b0;
        dl_cfg_wr_o     = 1'b0;
        chk_req_o       = 1'b0;
        done_o          = 1'b0;
        busy_o          = (state_q != S_IDLE);
        dl_delay_en_o   = (state_q != S_IDLE) || locked_q;
        unique case (state_q)
            S_CAL_SET: begin
                dl_sel_o        = SEL_CAL;
                dl_sampler_en_o = 1'b1;
                dl_cfg_wr_o     = 1'b1;
            end
            S_CAL_WAIT: begin
                dl_sel_o        = SEL_CAL;
                dl_sampler_en_o = 1'b1;
            end
            S_PH_SET, S_FINAL_SET: dl_cfg_wr_o = 1'b1;
            S_PH_REQ:              chk_req_o   = 1'b1;
            S_FINISH:              done_o      = 1'b1;
            default: ;
        endcase
        err_o         = done_o && (err_q != ERR_NONE);
        err_code_o    = err_q;
        final_unit_o  = fin_unit_q;
        final_phase_o = fin_phase_q;
    end
endmodule

// File: rtl/dlyt_tuner_chk.sv
`timescale 1ns/1ps
module dlyt_tuner_chk #(
    parameter int SEL_W    = 4,
    parameter int NB_DELAY = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             err_o,
    input logic             chk_req_o,
    input logic             dl_sampler_en_o,
    input logic             dl_delay_en_o,
    input logic             dl_cfg_wr_o,
    input logic [SEL_W-1:0] dl_sel_o,
    input logic [SEL_W-1:0] final_phase_o
);
    localparam logic [SEL_W-1:0] SEL_CAL = SEL_W'(NB_DELAY + 1);

    // R2
    cal_write_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_cfg_wr_o && dl_sampler_en_o) |-> (dl_delay_en_o && dl_sel_o == SEL_CAL));

    // R6
    trial_no_sampler_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_req_o |-> (!dl_sampler_en_o && dl_delay_en_o && dl_sel_o < SEL_W'(NB_DELAY)));

    // R6
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_req_o |=> !chk_req_o);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    // R10
    final_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(final_phase_o) && $stable(dl_sel_o)));
endmodule

bind dlyt_tuner dlyt_tuner_chk #(.SEL_W(SEL_W), .NB_DELAY(NB_DELAY)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .busy_o          (busy_o),
    .done_o          (done_o),
    .err_o           (err_o),
    .chk_req_o       (chk_req_o),
    .dl_sampler_en_o (dl_sampler_en_o),
    .dl_delay_en_o   (dl_delay_en_o),
    .dl_cfg_wr_o     (dl_cfg_wr_o),
    .dl_sel_o        (dl_sel_o),
    .final_phase_o   (final_phase_o)
);

// File: tb/tb_dlyt_tuner.sv
`timescale 1ns/1ps
module tb_dlyt_tuner;
    localparam int TMO = 16;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [6:0] dl_unit_o;
    logic [3:0] dl_sel_o;
    logic dl_delay_en_o, dl_sampler_en_o, dl_cfg_wr_o;
    logic dl_len_valid_i = 1'b0;
    logic [11:0] dl_len_i;
    logic chk_req_o;
    logic chk_done_i = 1'b0;
    logic chk_pass_i = 1'b0;
    logic busy_o, done_o, err_o;
    logic [1:0] err_code_o;
    logic [6:0] final_unit_o;
    logic [3:0] final_phase_o;

    always #2 clk = ~clk;

    dlyt_tuner #(.TIMEOUT_CYC(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .dl_unit_o(dl_unit_o), .dl_sel_o(dl_sel_o),
        .dl_delay_en_o(dl_delay_en_o), .dl_sampler_en_o(dl_sampler_en_o),
        .dl_cfg_wr_o(dl_cfg_wr_o), .dl_len_valid_i(dl_len_valid_i),
        .dl_len_i(dl_len_i), .chk_req_o(chk_req_o), .chk_done_i(chk_done_i),
        .chk_pass_i(chk_pass_i), .busy_o(busy_o), .done_o(done_o),
        .err_o(err_o), .err_code_o(err_code_o),
        .final_unit_o(final_unit_o), .final_phase_o(final_phase_o)
    );

    int errors = 0;
    int checks = 0;
    int scen = 0;
    logic [15:0] pmask = '0;

    // Line model state
    int  line_unit = 0;
    int  line_cnt  = 0;
    // Monitor state
    int  exp_unit_next = 0;
    int  exp_phase_next = 0;
    int  bad_cal = 0;
    int  bad_ph = 0;
    int  trials = 0;
    int  req_cnt = 0;
    int  req_sel = 0;

    function automatic bit resp_of(int u);
        case (scen)
            2: return (u >= 5);
            3: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic int len_of(int u);
        case (scen)
            1: return (u < 3) ? 4095 : 160;
            2: return (u == 5) ? 0 : 1024;
            4: return 1;
            5: return (u < 1) ? 2048 : 16;
            default: return 0;
        endcase
    endfunction

    assign dl_len_i = 12'(len_of(line_unit));

    // Delay-line and check responder, updated away from the active edge
    always @(negedge clk) begin
        if (dl_cfg_wr_o && dl_sampler_en_o) begin
            if (!(dl_delay_en_o && dl_sel_o == 4'd12 && int'(dl_unit_o) == exp_unit_next)) bad_cal++;
            exp_unit_next++;
            line_unit <= int'(dl_unit_o);
            line_cnt  <= LAT;
            dl_len_valid_i <= 1'b0;
        end else if (line_cnt > 0) begin
            line_cnt <= line_cnt - 1;
            if (line_cnt == 1 && resp_of(line_unit)) dl_len_valid_i <= 1'b1;
        end
        if (chk_req_o) begin
            if (!(dl_delay_en_o && !dl_sampler_en_o && int'(dl_sel_o) == exp_phase_next)) bad_ph++;
            exp_phase_next++;
            trials++;
            req_sel <= int'(dl_sel_o);
            req_cnt <= 2;
        end
        if (req_cnt == 1) begin
            chk_done_i <= 1'b1;
            chk_pass_i <= pmask[req_sel];
        end else begin
            chk_done_i <= 1'b0;
            chk_pass_i <= 1'b0;
        end
        if (req_cnt > 0) req_cnt <= req_cnt - 1;
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic run_case(input int sc, input logic [15:0] mask, input string name);
        int eu, emax, ecode, ephase, cur, best, bend, lim;
        bit found;
        scen = sc;
        pmask = mask;
        // Expected results from the requirements
        found = 0; eu = 0; emax = 0;
        for (int u = 0; u < 128 && !found; u++) begin
            if (resp_of(u) && len_of(u) > 0 && len_of(u) < 2048) begin
                found = 1; eu = u;
                for (int b = 0; b < 12; b++) if (len_of(u) & (1 << b)) emax = b;
            end
        end
        cur = 0; best = 0; bend = 0;
        if (found) begin
            for (int p = 0; p <= emax; p++) begin
                if (mask[p]) begin
                    cur++;
                    if (cur > best) begin best = cur; bend = p; end
                end else cur = 0;
            end
        end
        ecode  = !found ? 1 : (best == 0 ? 2 : 0);
        ephase = (ecode == 0) ? bend - best / 2 : 0;

        exp_unit_next = 0; exp_phase_next = 0; bad_cal = 0; bad_ph = 0; trials = 0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        lim = 0;
        while (!done_o && lim < 20000) begin @(negedge clk); lim++; end
        if (!done_o) begin
            errors++; checks++;
            $display("FAIL watchdog %s: actual=%0d expected=%0d", name, 0, 1);
            return;
        end
        check(err_code_o == 2'(ecode), {name, " R5 R9 error code"}, err_code_o, ecode);
        check(err_o == (ecode != 0), {name, " R10 err with done"}, err_o, ecode != 0);
        check(bad_cal == 0, {name, " R2 unit order/cal cfg"}, bad_cal, 0);
        check(exp_unit_next == (found ? eu + 1 : 128), {name, " R3 R4 units written"}, exp_unit_next, found ? eu + 1 : 128);
        check(bad_ph == 0, {name, " R6 trial cfg/order"}, bad_ph, 0);
        check(trials == (found ? emax + 1 : 0), {name, " R4 R6 trial count"}, trials, found ? emax + 1 : 0);
        if (ecode == 0) begin
            check(final_unit_o == 7'(eu), {name, " R8 final unit"}, final_unit_o, eu);
            check(final_phase_o == 4'(ephase), {name, " R7 R8 final phase"}, final_phase_o, ephase);
        end
        @(negedge clk);
        check(done_o == 1'b0, {name, " R10 done one cycle"}, done_o, 0);
        repeat (4) @(negedge clk);
        check(final_phase_o == 4'(ephase) && (ecode != 0 || dl_sel_o == 4'(ephase)),
              {name, " R10 final held"}, final_phase_o, ephase);
        check(dl_delay_en_o == (ecode == 0) && !dl_sampler_en_o, {name, " R8 line left enabled"}, dl_delay_en_o, ecode == 0);
    endtask

    task automatic test_reset();
        check(!busy_o && !done_o && !err_o && !chk_req_o, "R1 idle flags", busy_o, 0);
        check(!dl_delay_en_o && !dl_sampler_en_o, "R1 line disabled", dl_delay_en_o, 0);
        check(final_unit_o == 0 && final_phase_o == 0 && err_code_o == 0, "R1 final regs", final_phase_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        // tie of two windows -> earliest kept (R7), oversize lengths rejected (R4)
        run_case(1, 16'b0000_0000_0011_0110, "tie");
        // timeouts then zero length (R3 R4), all phases pass
        run_case(2, 16'hFFFF, "timeout");
        // window reaching last phase, length 2048 rejected (R4)
        run_case(5, 16'b0000_0000_0001_1101, "endwin");
        // single phase, failing -> no window (R9)
        run_case(4, 16'h0000, "nowin");
        // single phase, passing
        run_case(4, 16'h0001, "onephase");
        // nothing accepted (R5)
        run_case(3, 16'h0000, "calfail");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule